// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block connects a small set of shared, level-sensitive PCI interrupt request lines to the inputs of a legacy interrupt controller. Each shared line has one routing byte. The byte either names one controller input or turns the route off. A controller input is asserted while any shared line steered to it is asserted. Several shared lines can therefore merge onto one input.

Software sets the routes through a 32-bit configuration write port. The port has a byte address and four byte enables. A read port returns the stored bytes. A new route takes effect on the outputs at the same clock edge that stores it, so a route change never leaves an output stale.

A separate combinational helper works out which shared line a device interrupt pin drives. It rotates the pin index by the device's slot number.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte holds 0x80 and every `irq_out` bit is 0, even while `pirq_in` lines are asserted.
- R2: The routing byte for shared line n is at byte address 0x60+n, in the byte lane given by address bits [1:0]. Lane 0 is `cfg_wdata[7:0]`. A write updates only the lanes whose `cfg_be` bit is set. A write to any other dword address leaves all routes unchanged.
- R3: Reading a dword through `cfg_rd_addr` returns the last byte written to each routing address in its lane. Lanes that hold no routing byte read 0.
- R4: A routing value of 16 or more disables that route. The shared line then has no effect on any `irq_out` bit.
- R5: When routing byte n holds k < 16, `irq_out[k]` follows `pirq_in[n]` with one clock of latency.
- R6: `irq_out[k]` is the OR of all shared lines routed to k. It stays asserted while any one of them remains asserted.
- R7: A routing write changes `irq_out` at the same edge that stores the write, using the current `pirq_in` levels.
- R8: `slot_pirq` equals (`intx_pin` + `slot_num` − 1) mod 4, combinationally. `intx_pin` is 0 for INTA through 3 for INTD.
- R9: With no shared line asserted, every `irq_out` bit is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Write byte address (dword selected by bits [7:2]) |
| cfg_wdata | input | 32 | Write data, lane j in bits [8j+7:8j] |
| cfg_be | input | 4 | Write byte enables |
| cfg_rd_addr | input | 8 | Read byte address (dword selected by bits [7:2]) |
| cfg_rdata | output | 32 | Read data for the selected dword |
| pirq_in | input | 4 | Shared PCI interrupt levels, bit n is line n |
| irq_out | output | 16 | Registered interrupt-controller levels |
| slot_num | input | 5 | Device number of the requesting device |
| intx_pin | input | 2 | Device interrupt pin index |
| slot_pirq | output | 2 | Shared line that the pin drives |

## Verification
The bench builds the block with its default parameters: four shared lines, sixteen outputs and routing bytes starting at 0x60. With these values all four routing bytes share one dword, so byte enables alone decide which routes a write changes. The 16-value threshold and the 0x80 reset code both fall on real disable cases. The slot helper is swept over all 32 device numbers and all four pins, which covers every wrap of the rotation.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int              NUM_PIRQ   = 4,
  parameter int              NUM_IRQ    = 16,
  parameter int              AW         = 8,
  parameter int              SLOT_W     = 5,
  parameter logic [AW-1:0]   ROUTE_BASE = 8'h60,
  parameter logic [7:0]      ROUTE_RST  = 8'h80
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr_en,
  input  logic [AW-1:0]               cfg_addr,
  input  logic [31:0]                 cfg_wdata,
  input  logic [3:0]                  cfg_be,
  input  logic [AW-1:0]               cfg_rd_addr,
  output logic [31:0]                 cfg_rdata,
  input  logic [NUM_PIRQ-1:0]         pirq_in,
  output logic [NUM_IRQ-1:0]          irq_out,
  input  logic [SLOT_W-1:0]           slot_num,
  input  logic [$clog2(NUM_PIRQ)-1:0] intx_pin,
  output logic [$clog2(NUM_PIRQ)-1:0] slot_pirq
);

  localparam int PW = $clog2(NUM_PIRQ);

  logic [NUM_PIRQ-1:0][7:0] route_q;
  logic [NUM_PIRQ-1:0][7:0] route_nxt;
  logic [NUM_IRQ-1:0]       irq_nxt;

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_route
    localparam logic [AW-1:0] RADDR = AW'(ROUTE_BASE + AW'(n));
    localparam int            LANE  = int'(RADDR[1:0]);
    logic hit;
    assign hit          = cfg_wr_en && (cfg_addr[AW-1:2] == RADDR[AW-1:2]) && cfg_be[LANE];
    assign route_nxt[n] = hit ? cfg_wdata[8*LANE +: 8] : route_q[n];

    always_ff @(posedge clk) begin
      if (!rst_n) route_q[n] <= ROUTE_RST;
      else        route_q[n] <= route_nxt[n];
    end
  end

  always_comb begin
    irq_nxt = '0;
    for (int k = 0; k < NUM_IRQ; k++)
      for (int n = 0; n < NUM_PIRQ; n++)
        if (route_nxt[n] == 8'(k) && pirq_in[n]) irq_nxt[k] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= irq_nxt;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int n = 0; n < NUM_PIRQ; n++) begin
      logic [AW-1:0] ra;
      ra = AW'(ROUTE_BASE + AW'(n));
      if (cfg_rd_addr[AW-1:2] == ra[AW-1:2])
        cfg_rdata[8*ra[1:0] +: 8] = route_q[n];
    end
  end

  assign slot_pirq = intx_pin + slot_num[PW-1:0] - PW'(1);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_in == '0) |=> (irq_out == '0));

  // R6
  fanin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones($past(pirq_in)));

  // R2
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_en |=> $stable(route_q));

  // R8
  slot_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_num == SLOT_W'(1)) |-> (slot_pirq == intx_pin));

endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [7:0]  cfg_rd_addr = 8'h60;
  logic [31:0] cfg_rdata;
  logic [3:0]  pirq_in = '0;
  logic [15:0] irq_out;
  logic [4:0]  slot_num = '0;
  logic [1:0]  intx_pin = '0;
  logic [1:0]  slot_pirq;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] m_route [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rdata(cfg_rdata), .pirq_in(pirq_in), .irq_out(irq_out),
    .slot_num(slot_num), .intx_pin(intx_pin), .slot_pirq(slot_pirq)
  );

  function automatic logic [15:0] model_irq();
    logic [15:0] r = '0;
    for (int n = 0; n < 4; n++)
      if (m_route[n] < 8'd16 && pirq_in[n]) r[m_route[n][3:0]] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_wr_en = 1'b0; pirq_in = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) m_route[n] = 8'h80;
  endtask

  task automatic wr(logic [7:0] addr, logic [31:0] data, logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = addr; cfg_wdata = data; cfg_be = be;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    if (addr[7:2] == 6'h18)
      for (int j = 0; j < 4; j++)
        if (be[j]) m_route[j] = data[8*j +: 8];
  endtask

  task automatic set_pirq(logic [3:0] v);
    @(negedge clk);
    pirq_in = v;
    @(posedge clk); #1;
  endtask

  task automatic read_route(string req, logic [7:0] addr, logic [31:0] exp);
    @(negedge clk);
    cfg_rd_addr = addr;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic test_reset();
    do_reset();
    @(posedge clk); #1;
    check("R1 irq after reset", {16'h0, irq_out}, 32'h0);
    read_route("R1 routes after reset", 8'h60, 32'h80808080);
    set_pirq(4'hF);
    check("R1 reset routes disabled", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic test_single();
    do_reset();
    wr(8'h60, 32'h0000_0005, 4'b0001);
    set_pirq(4'b0001);
    check("R5 route A to 5", {16'h0, irq_out}, 32'h0020);
    @(negedge clk);
    pirq_in = 4'b0000;
    #1;
    check("R5 latency hold", {16'h0, irq_out}, 32'h0020);
    @(posedge clk); #1;
    check("R9 deassert clears", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic test_disable();
    do_reset();
    wr(8'h60, 32'h0F80_FF10, 4'b1111);
    set_pirq(4'hF);
    check("R4 only D routed", {16'h0, irq_out}, 32'h8000);
    check("R4 model", {16'h0, irq_out}, {16'h0, model_irq()});
  endtask

  task automatic test_merge();
    do_reset();
    wr(8'h60, 32'h8003_8003, 4'b1111);
    set_pirq(4'b0101);
    check("R6 both high", {16'h0, irq_out}, 32'h0008);
    set_pirq(4'b0100);
    check("R6 one remains", {16'h0, irq_out}, 32'h0008);
    set_pirq(4'b0001);
    check("R6 other remains", {16'h0, irq_out}, 32'h0008);
    set_pirq(4'b0000);
    check("R9 none asserted", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic test_resteer();
    do_reset();
    wr(8'h60, 32'h0000_0002, 4'b0001);
    set_pirq(4'b0001);
    check("R7 initial route", {16'h0, irq_out}, 32'h0004);
    wr(8'h60, 32'h0000_0009, 4'b0001);
    check("R7 same-edge resteer", {16'h0, irq_out}, 32'h0200);
    wr(8'h60, 32'h0000_0080, 4'b0001);
    check("R7 resteer to off", {16'h0, irq_out}, 32'h0);
  endtask

  task automatic test_lanes();
    do_reset();
    wr(8'h60, 32'h0404_0303, 4'b0010);
    read_route("R2 lane B only", 8'h60, 32'h80800380);
    set_pirq(4'hF);
    check("R2 only B routed", {16'h0, irq_out}, 32'h0008);
    wr(8'h64, 32'h0101_0101, 4'b1111);
    read_route("R2 other dword ignored", 8'h60, 32'h80800380);
    set_pirq(4'hF);
    check("R2 irq after ignored write", {16'h0, irq_out}, {16'h0, model_irq()});
    wr(8'h63, 32'h0700_0000, 4'b1000);
    set_pirq(4'hF);
    check("R2 lane D", {16'h0, irq_out}, 32'h0088);
  endtask

  task automatic test_readback();
    do_reset();
    wr(8'h60, 32'h1122_3344, 4'b1111);
    read_route("R3 readback", 8'h60, 32'h11223344);
    read_route("R3 other dword zero", 8'h64, 32'h0);
    read_route("R3 lower dword zero", 8'h5C, 32'h0);
  endtask

  task automatic test_slot();
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++) begin
        slot_num = 5'(s);
        intx_pin = 2'(p);
        #1;
        check("R8 slot rotation", {30'h0, slot_pirq}, 32'((p + s + 3) % 4));
      end
  endtask

  initial begin
    test_reset();
    test_single();
    test_disable();
    test_merge();
    test_resteer();
    test_lanes();
    test_readback();
    test_slot();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule